// File: doc/BRIEF.md
# Serial DAC Write Sequencer

This block sits on the host side of a 14-bit serial-input DAC. It takes one conversion code at a time over a valid/ready handshake and turns it into a 16-bit serial frame: the code, most significant bit first, then two zero padding bits. It drives an active-low chip select, a serial clock and a data line. In four-wire mode it also drives an active-low load strobe that commits the frame after chip select has gone high. In three-wire mode the strobe stays high, because the DAC takes the word on the rising edge of chip select.

All pin timing comes from counting system-clock cycles. Each parameter holds a cycle count that the integrator rounds up from the DAC's nanosecond minimums for the system clock in use. The defaults suit a 100 MHz clock. After reset the block waits out the DAC's power-up delay before it offers `in_ready`.

Back-pressure is simple. `in_ready` is high only while the sequencer is idle. A code is taken on any clock edge where `in_valid` and `in_ready` are both high. While a frame, its load pulse or the gap after it is in progress, `in_ready` stays low and `in_valid`, `in_code` and `four_wire` are ignored. There is no buffering, so a source that holds `in_valid` high is served as soon as the sequencer returns to idle.

Top module: `dac_write_ctrl`

## Requirements
- R1: While reset is asserted, `dac_cs_n` is high, `dac_sclk` is low, `dac_ld_n` is high and `in_ready` is low.
- R2: After reset is released, `dac_cs_n` stays high and `in_ready` stays low for at least `PWRUP_CYC` clock cycles.
- R3: A code is accepted only on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low from that point until the frame's tail completes. `in_valid` and `in_code` are ignored while `in_ready` is low, and no frame starts while `in_valid` is low.
- R4: Each frame has exactly 16 rising edges of `dac_sclk` while `dac_cs_n` is low. The bits sampled on those edges are the accepted code bit 13 down to bit 0, then two zeros.
- R5: Every high phase of `dac_sclk` lasts at least `SCLK_HI_CYC` cycles and every low phase within a frame lasts at least `SCLK_LO_CYC` cycles. The high share of each period is between 40% and 60%.
- R6: `dac_cs_n` falls at least `CS_SETUP_CYC` cycles before the first rising edge of `dac_sclk`. It rises at least `CS_HOLD_CYC` cycles after the last rising edge. `dac_sclk` is low whenever `dac_cs_n` changes or is high.
- R7: `dac_din` has been stable for at least `SCLK_LO_CYC - 1` cycles when `dac_sclk` rises, and it does not change while `dac_sclk` is high.
- R8: In four-wire mode, `dac_ld_n` is high while `dac_cs_n` is low. Each frame produces exactly one low pulse on `dac_ld_n`. The pulse starts `LD_SETUP_CYC` cycles after `dac_cs_n` rises and lasts `LD_LOW_CYC` cycles.
- R9: In three-wire mode, `dac_ld_n` stays high for the whole frame and its tail.
- R10: Between consecutive frames, `dac_cs_n` stays high for at least `CS_GAP_CYC` cycles.
- R11: The mode is taken from `four_wire` (1 = four-wire) on the accepting cycle. Later changes of `four_wire` do not affect a frame already accepted.
- R12: `in_ready` rises exactly T cycles after `dac_cs_n` rises. In three-wire mode T is `CS_GAP_CYC`. In four-wire mode T is the larger of `CS_GAP_CYC` and `LD_SETUP_CYC + LD_LOW_CYC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A code is offered |
| in_code | input | CODE_W | Code to write, MSB sent first |
| four_wire | input | 1 | 1 = issue a load pulse after the frame; sampled on acceptance |
| in_ready | output | 1 | Sequencer idle and able to take a code |
| dac_cs_n | output | 1 | Active-low chip select to the DAC |
| dac_sclk | output | 1 | Serial clock to the DAC; data is taken on its rising edge |
| dac_din | output | 1 | Serial data to the DAC |
| dac_ld_n | output | 1 | Active-low load strobe to the DAC |

## Verification
The bench keeps the 100 MHz defaults for the clock phases, setup, hold and load-pulse counts, and it keeps the full 2000-cycle power-up wait. It raises `CS_GAP_CYC` to 12. That value is larger than the 10-cycle load span, so four-wire frames pass through a two-cycle trailing gap after the load pulse, and both branches of R12 give the same 12-cycle ready latency by different paths. Codes with alternating bits, all ones, all zeros and single set bits exercise every data transition against the clock edges.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

  typedef enum logic [3:0] {
    S_PWRUP,
    S_IDLE,
    S_SETUP,
    S_HIGH,
    S_LOW,
    S_HOLD,
    S_LDSET,
    S_LDLOW,
    S_GAP
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacw_timer.sv
module dacw_timer #(
  parameter int TW      = 12,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);

  logic [TW-1:0] cnt;

  // Counts down from load_val; the interval lasts load_val+1 cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= TW'(RST_VAL);
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/dacw_shift.sv
module dacw_shift #(
  parameter int CODE_W = 14,
  parameter int SUB_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              shift,
  output logic              din,
  output logic              last_bit
);

  localparam int FW = CODE_W + SUB_W;
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] sr;
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      left <= '0;
    end else if (load) begin
      sr   <= {code, {SUB_W{1'b0}}};
      left <= CW'(FW);
    end else if (shift) begin
      sr   <= {sr[FW-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end

  assign din      = sr[FW-1];
  assign last_bit = (left == CW'(1));

endmodule

// File: rtl/dacw_seq.sv
module dacw_seq
  import dacw_pkg::*;
#(
  parameter int SCLK_HI_CYC  = 5,
  parameter int SCLK_LO_CYC  = 5,
  parameter int CS_SETUP_CYC = 5,
  parameter int CS_HOLD_CYC  = 3,
  parameter int LD_SETUP_CYC = 5,
  parameter int LD_LOW_CYC   = 5,
  parameter int CS_GAP_CYC   = 10,
  parameter int TW           = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          four_wire,
  input  logic          tmr_done,
  input  logic          last_bit,
  output logic          in_ready,
  output logic          accept,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          shift,
  output logic          cs_n,
  output logic          sclk,
  output logic          ld_n
);

  localparam int LD_SPAN = LD_SETUP_CYC + LD_LOW_CYC;
  localparam int GAP4    = (CS_GAP_CYC > LD_SPAN) ? CS_GAP_CYC - LD_SPAN : 0;
  localparam int GAP4_V  = (GAP4 > 0) ? GAP4 - 1 : 0;

  seq_state_e st, nxt;
  logic       mode_q;
  logic       rdy_q, cs_n_q, sclk_q, ld_n_q;

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    shift    = 1'b0;
    unique case (st)
      S_PWRUP: if (tmr_done) nxt = S_IDLE;
      S_IDLE: if (in_valid) begin
        nxt = S_SETUP; tmr_load = 1'b1; tmr_val = TW'(CS_SETUP_CYC - 1);
      end
      S_SETUP: if (tmr_done) begin
        nxt = S_HIGH; tmr_load = 1'b1; tmr_val = TW'(SCLK_HI_CYC - 1);
      end
      S_HIGH: if (tmr_done) begin
        tmr_load = 1'b1;
        if (last_bit) begin
          nxt = S_HOLD; tmr_val = TW'(CS_HOLD_CYC - 1);
        end else begin
          nxt = S_LOW; tmr_val = TW'(SCLK_LO_CYC - 1); shift = 1'b1;
        end
      end
      S_LOW: if (tmr_done) begin
        nxt = S_HIGH; tmr_load = 1'b1; tmr_val = TW'(SCLK_HI_CYC - 1);
      end
      S_HOLD: if (tmr_done) begin
        tmr_load = 1'b1;
        if (mode_q) begin
          nxt = S_LDSET; tmr_val = TW'(LD_SETUP_CYC - 1);
        end else begin
          nxt = S_GAP; tmr_val = TW'(CS_GAP_CYC - 1);
        end
      end
      S_LDSET: if (tmr_done) begin
        nxt = S_LDLOW; tmr_load = 1'b1; tmr_val = TW'(LD_LOW_CYC - 1);
      end
      S_LDLOW: if (tmr_done) begin
        if (GAP4 > 0) begin
          nxt = S_GAP; tmr_load = 1'b1; tmr_val = TW'(GAP4_V);
        end else begin
          nxt = S_IDLE;
        end
      end
      S_GAP: if (tmr_done) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign accept = in_valid && rdy_q;

  // Pin values are registered from the next state so they change cleanly with it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_PWRUP;
      rdy_q  <= 1'b0;
      cs_n_q <= 1'b1;
      sclk_q <= 1'b0;
      ld_n_q <= 1'b1;
      mode_q <= 1'b0;
    end else begin
      st     <= nxt;
      rdy_q  <= (nxt == S_IDLE);
      cs_n_q <= !(nxt inside {S_SETUP, S_HIGH, S_LOW, S_HOLD});
      sclk_q <= (nxt == S_HIGH);
      ld_n_q <= (nxt != S_LDLOW);
      if (accept) mode_q <= four_wire;
    end
  end

  assign in_ready = rdy_q;
  assign cs_n     = cs_n_q;
  assign sclk     = sclk_q;
  assign ld_n     = ld_n_q;

endmodule

// File: rtl/dac_write_ctrl.sv
module dac_write_ctrl
  import dacw_pkg::*;
#(
  parameter int CODE_W       = 14,
  parameter int SUB_W        = 2,
  parameter int SCLK_HI_CYC  = 5,
  parameter int SCLK_LO_CYC  = 5,
  parameter int CS_SETUP_CYC = 5,
  parameter int CS_HOLD_CYC  = 3,
  parameter int LD_SETUP_CYC = 5,
  parameter int LD_LOW_CYC   = 5,
  parameter int CS_GAP_CYC   = 10,
  parameter int PWRUP_CYC    = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  input  logic              four_wire,
  output logic              in_ready,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_din,
  output logic              dac_ld_n
);

  localparam int MAXD = imax(imax(imax(SCLK_HI_CYC, SCLK_LO_CYC), imax(CS_SETUP_CYC, CS_HOLD_CYC)),
                             imax(imax(LD_SETUP_CYC, LD_LOW_CYC), imax(CS_GAP_CYC, PWRUP_CYC)));
  localparam int TW   = $clog2(MAXD + 1);

  logic          accept, shift, last_bit, tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;

  dacw_timer #(.TW(TW), .RST_VAL(PWRUP_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  dacw_shift #(.CODE_W(CODE_W), .SUB_W(SUB_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .code(in_code), .shift(shift),
    .din(dac_din), .last_bit(last_bit)
  );

  dacw_seq #(
    .SCLK_HI_CYC(SCLK_HI_CYC), .SCLK_LO_CYC(SCLK_LO_CYC),
    .CS_SETUP_CYC(CS_SETUP_CYC), .CS_HOLD_CYC(CS_HOLD_CYC),
    .LD_SETUP_CYC(LD_SETUP_CYC), .LD_LOW_CYC(LD_LOW_CYC),
    .CS_GAP_CYC(CS_GAP_CYC), .TW(TW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .four_wire(four_wire),
    .tmr_done(tmr_done), .last_bit(last_bit), .in_ready(in_ready), .accept(accept),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .shift(shift),
    .cs_n(dac_cs_n), .sclk(dac_sclk), .ld_n(dac_ld_n)
  );

endmodule

// File: rtl/dacw_checker.sv
module dacw_checker #(
  parameter int PWRUP_CYC   = 2000,
  parameter int SCLK_HI_CYC = 5
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic din,
  input logic ld_n,
  input logic ready
);

  localparam int PW = $clog2(PWRUP_CYC + 1);

  logic [PW-1:0] pw_cnt;
  logic [7:0]    hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_cnt <= '0;
      hi_run <= '0;
    end else begin
      if (pw_cnt < PW'(PWRUP_CYC)) pw_cnt <= pw_cnt + 1'b1;
      if (!sclk) hi_run <= '0;
      else if (hi_run != 8'hFF) hi_run <= hi_run + 1'b1;
    end
  end

  p_pwrup_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_cnt < PW'(PWRUP_CYC)) |-> (cs_n && !ready));

  p_ready_only_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cs_n && ld_n && !sclk));

  p_sclk_high_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_run >= 8'(SCLK_HI_CYC)));

  p_sclk_low_cs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_din_stable_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(din));

  p_ld_idle_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> ld_n);

endmodule

bind dac_write_ctrl dacw_checker #(.PWRUP_CYC(PWRUP_CYC), .SCLK_HI_CYC(SCLK_HI_CYC)) u_dacw_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(dac_cs_n), .sclk(dac_sclk),
  .din(dac_din), .ld_n(dac_ld_n), .ready(in_ready)
);

// File: tb/test_dac_write_ctrl.sv
module test_dac_write_ctrl;

  localparam int PWR = 2000;
  localparam int GAP = 12;
  localparam int HI = 5, LO = 5, SET = 5, HOLD = 3, LDS = 5, LDW = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [13:0] in_code = '0;
  logic        four_wire = 1'b0;
  logic        in_ready, dac_cs_n, dac_sclk, dac_din, dac_ld_n;

  always #5 clk = ~clk;

  dac_write_ctrl #(.CS_GAP_CYC(GAP)) i_dac_write_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
    .four_wire(four_wire), .in_ready(in_ready), .dac_cs_n(dac_cs_n),
    .dac_sclk(dac_sclk), .dac_din(dac_din), .dac_ld_n(dac_ld_n)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Pin monitor sampled on the falling clock edge
  int cyc, t_csfall, t_csrise, t_rise, t_fall, t_ldfall, din_age;
  int t_first_fall, t_first_ready, n_csfall;
  int f_nrise, f_setup, f_hold, f_hi_min, f_lo_min, f_dinage, f_glitch, f_edge_bad;
  int f_ldcnt, f_ldset, f_ldw, f_rdylat, f_gap, f_duty_bad, hi_last;
  bit f_done, f_csup;
  logic [15:0] f_word;
  logic p_cs, p_sclk, p_din, p_ld, p_rdy;

  task automatic clr();
    f_nrise = 0; f_setup = 0; f_hold = 0; f_hi_min = 999; f_lo_min = 999; f_dinage = 999;
    f_glitch = 0; f_edge_bad = 0; f_ldcnt = 0; f_ldset = 0; f_ldw = 0; f_rdylat = 0;
    f_gap = 999; f_duty_bad = 0; f_done = 0; f_csup = 0; f_word = '0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; t_csfall = 0; t_csrise = 0; t_rise = 0; t_fall = 0; t_ldfall = 0; din_age = 0;
      t_first_fall = 0; t_first_ready = 0; n_csfall = 0; hi_last = 0;
      p_cs = 1'b1; p_sclk = 1'b0; p_din = 1'b0; p_ld = 1'b1; p_rdy = 1'b0;
    end else begin
      cyc++;
      if (dac_din !== p_din) din_age = 0; else din_age++;
      if (dac_sclk && p_sclk && dac_din !== p_din) f_glitch++;
      if (!dac_cs_n && p_cs) begin
        f_gap = cyc - t_csrise; t_csfall = cyc; n_csfall++;
        if (t_first_fall == 0) t_first_fall = cyc;
        if (dac_sclk) f_edge_bad++;
      end
      if (dac_sclk && !p_sclk) begin
        if (f_nrise == 0) f_setup = cyc - t_csfall;
        else begin
          if (cyc - t_fall < f_lo_min) f_lo_min = cyc - t_fall;
          if (hi_last * 5 < 2 * (cyc - t_rise) || hi_last * 5 > 3 * (cyc - t_rise)) f_duty_bad++;
        end
        if (din_age < f_dinage) f_dinage = din_age;
        if (dac_cs_n) f_edge_bad++;
        f_word = {f_word[14:0], dac_din}; f_nrise++; t_rise = cyc;
      end
      if (!dac_sclk && p_sclk) begin
        hi_last = cyc - t_rise;
        if (hi_last < f_hi_min) f_hi_min = hi_last;
        t_fall = cyc;
      end
      if (dac_cs_n && !p_cs) begin
        f_hold = cyc - t_rise; t_csrise = cyc; f_csup = 1;
        if (dac_sclk) f_edge_bad++;
      end
      if (!dac_ld_n && p_ld) begin f_ldcnt++; f_ldset = cyc - t_csrise; t_ldfall = cyc; end
      if (dac_ld_n && !p_ld) f_ldw = cyc - t_ldfall;
      if (!dac_ld_n && !dac_cs_n) f_edge_bad++;
      if (in_ready && !p_rdy) begin
        f_rdylat = cyc - t_csrise; f_done = 1;
        if (t_first_ready == 0) t_first_ready = cyc;
      end
      p_cs = dac_cs_n; p_sclk = dac_sclk; p_din = dac_din; p_ld = dac_ld_n; p_rdy = in_ready;
    end
  end

  task automatic step(); @(negedge clk); #1; endtask

  task automatic offer(input logic [13:0] code, input bit mode);
    while (!in_ready) step();
    in_valid = 1'b1; in_code = code; four_wire = mode;
    step();
    in_valid = 1'b0;
  endtask

  task automatic wait_done(); while (!f_done) step(); endtask

  task automatic check_frame(input logic [13:0] code, input bit mode);
    int lat;
    lat = (mode && (LDS + LDW > GAP)) ? LDS + LDW : GAP;
    chk(f_word == {code, 2'b00}, "R4", "frame bits", int'(f_word), int'({code, 2'b00}));
    chk(f_nrise == 16, "R4", "rising edges", f_nrise, 16);
    chk(f_hi_min >= HI && f_lo_min >= LO && f_duty_bad == 0, "R5", "sclk phases", f_hi_min * 100 + f_lo_min, HI * 100 + LO);
    chk(f_setup >= SET && f_hold >= HOLD && f_edge_bad == 0, "R6", "cs setup/hold", f_setup * 100 + f_hold, SET * 100 + HOLD);
    chk(f_dinage >= LO - 1 && f_glitch == 0, "R7", "din stability", f_dinage, LO - 1);
    chk(f_gap >= GAP, "R10", "cs high gap", f_gap, GAP);
    chk(f_rdylat == lat, "R12", "ready latency", f_rdylat, lat);
    if (mode) begin
      chk(f_ldcnt == 1 && f_ldset == LDS && f_ldw == LDW, "R8", "load pulse", f_ldcnt * 10000 + f_ldset * 100 + f_ldw, 10000 + LDS * 100 + LDW);
    end else begin
      chk(f_ldcnt == 0, "R9", "no load pulse", f_ldcnt, 0);
    end
  endtask

  task automatic t_reset();
    repeat (3) step();
    chk(dac_cs_n == 1'b1 && dac_sclk == 1'b0, "R1", "cs_n/sclk in reset", {dac_cs_n, dac_sclk}, 2);
    chk(dac_ld_n == 1'b1 && in_ready == 1'b0, "R1", "ld_n/ready in reset", {dac_ld_n, in_ready}, 2);
  endtask

  task automatic t_powerup();
    rst_n = 1'b1;
    while (!in_ready) step();
    chk(t_first_ready >= PWR, "R2", "ready after power-up", t_first_ready, PWR);
    chk(n_csfall == 0, "R2", "cs_n quiet in power-up", n_csfall, 0);
  endtask

  task automatic t_frame(input logic [13:0] code, input bit mode);
    clr(); offer(code, mode); wait_done(); check_frame(code, mode);
  endtask

  task automatic t_ignore_busy();
    int falls;
    clr();
    offer(14'h0F0F, 1'b0);
    in_valid = 1'b1; in_code = 14'h3333; four_wire = 1'b1;
    while (!f_csup) step();
    in_valid = 1'b0;
    wait_done();
    chk(f_word == {14'h0F0F, 2'b00}, "R3", "busy offer ignored", int'(f_word), int'({14'h0F0F, 2'b00}));
    chk(f_ldcnt == 0, "R11", "mode held from accept", f_ldcnt, 0);
    falls = n_csfall;
    repeat (30) step();
    chk(n_csfall == falls && in_ready, "R3", "no frame without valid", n_csfall - falls, 0);
  endtask

  initial begin
    clr();
    t_reset();
    t_powerup();
    t_frame(14'h0000, 1'b0);
    t_frame(14'h3FFF, 1'b1);
    t_frame(14'h2AAA, 1'b0);
    t_frame(14'h1555, 1'b1);
    t_frame(14'h2001, 1'b0);
    t_ignore_busy();
    t_frame(14'h0002, 1'b1);
    t_frame(14'h3FFE, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule